// File: doc/BRIEF.md
# Dual-Law Voice Compander

This block converts linear voice samples to 8-bit companded codes and 8-bit codes back to linear samples. It works under either of the two telephone companding laws: the logarithmic law with a bias of 33 (called mu-law below) and the segmented law with alternate-bit inversion (called A-law below). One select input chooses the law at run time. Both laws share one encode datapath, with a single segment finder and a single step shifter, and one expand datapath.

The transmit direction takes a 16-bit left-aligned two's-complement sample and returns its code. The receive direction takes a code and returns the linear value at the middle of that code's step, in the same left-aligned format. The two directions are independent. Each one registers its result, so a result appears one clock after its input is sampled. Framing, filtering and rate control belong to neighbouring blocks.

Top module: `voice_compander`

## Requirements
- R1: `law_sel` low selects mu-law and high selects A-law, in both directions. Its safe default is low (mu-law). The same input values give law-specific results.
- R2: A code carries its sign in bit 7, its segment (chord) in bits 6..4 and its step in bits 3..0. Bit 7 is 1 for a sample with sign bit 0 and 0 for a sample with sign bit 1.
- R3: In mu-law, the sample is `lin_in[15:2]`, 14 bits. A negative sample's magnitude is its bitwise inverse. The biased value b = min(mag, 8159) + 33 has its highest set bit at position p. The chord is p-5 and the step is bits p-1..p-4 of b. Both fields are sent inverted. Chords begin at magnitudes 31, 95, 223, 479, 991, 2015 and 4063.
- R4: In mu-law, magnitude 0 gives 0xFF when positive and 0x7F when negative. Positive and negative full scale give 0x80 and 0x00.
- R5: In mu-law, every magnitude of 8159 or more encodes to the full-scale code of its sign (0x80 or 0x00) and never wraps.
- R6: In A-law, the sample is `lin_in[15:3]`, 13 bits. A negative sample's magnitude is its bitwise inverse. Chord 0 holds magnitudes 0..31 with step = mag[4:1]. Chord c ≥ 1 starts at magnitude 16·2^c and has step = mag[c+3:c]. The 7-bit chord/step field is then XORed with 0x55.
- R7: In A-law, magnitude 0 gives 0xD5 (positive) and 0x55 (negative). Full scale gives 0xAA (positive) and 0x2A (negative).
- R8: The mu-law expander inverts bits 6..0 to get chord c and step s. Its magnitude is ((2s+33)<<c) - 33. The result is negative when bit 7 is 0 and is returned shifted left by 2.
- R9: The A-law expander XORs bits 6..0 with 0x55. Its magnitude is 2s+1 for c=0, 2s+33 for c=1 and (2s+33)<<(c-1) otherwise. The result is negative when bit 7 is 0 and is returned shifted left by 3.
- R10: Both outputs are registers. They change only at a rising clock edge, one clock after the input is sampled, and each direction ignores the other's input. A synchronous reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| law_sel | input | 1 | 0 = mu-law, 1 = A-law |
| lin_in | input | 16 | Left-aligned two's-complement sample to encode |
| code_out | output | 8 | Registered companded code |
| code_in | input | 8 | Companded code to expand |
| lin_out | output | 16 | Registered left-aligned linear value |

## Verification
The main internal hazard is an off-by-one in the segment finder or the step shift. Such an error moves a code by one step or one chord at the exact chord boundaries, one clock after the sample is applied. For that reason, the test vectors sit on both sides of each boundary.

A missing A-law inversion or a wrong mu-law bias corrupts every code from the first registered result, including the fixed zero and full-scale codes. A clip that wraps shows at once as a small code for the largest samples. Sign handling errors flip bit 7 or the sign of `lin_out` in the same cycle.

// File: rtl/compander_pkg.sv
package compander_pkg;
  localparam int CODE_W    = 8;   // sign + chord + step
  localparam int SEG_W     = 3;
  localparam int STEP_W    = 4;
  localparam int MU_W      = 14;  // mu-law sample width
  localparam int A_W       = 13;  // A-law sample width
  localparam int MU_BIAS   = 33;
  localparam int MU_CLIP   = 8159;
  localparam int SEG_FLOOR = 4;   // lowest bit position the finder reports
  localparam int K_W       = 4;   // finder output width (values 0..9)
  localparam int MU_TOP_K  = 8;   // above this the mu-law value saturates
  localparam logic [CODE_W-2:0] A_EVEN_MASK = 7'h55;
endpackage

// File: rtl/cmp_lead_finder.sv
module cmp_lead_finder #(
  parameter int W     = 14,
  parameter int FLOOR = 4,
  parameter int OUT_W = 4
) (
  input  logic [W-1:0]     val,
  output logic [OUT_W-1:0] k
);
  // k = max(position of highest one, FLOOR) - FLOOR
  always_comb begin
    k = '0;
    for (int i = FLOOR + 1; i < W; i++) begin
      if (val[i]) k = OUT_W'(i - FLOOR);
    end
  end
endmodule

// File: rtl/cmp_encode.sv
module cmp_encode
  import compander_pkg::*;
#(
  parameter int LIN_W = 16
) (
  input  logic [LIN_W-1:0]  lin,
  input  logic              law,
  output logic [CODE_W-1:0] code
);
  localparam int MAG_MU_W = MU_W - 1;
  localparam int MAG_A_W  = A_W - 1;

  logic                neg;
  logic [MU_W-1:0]     mu_x;
  logic [A_W-1:0]      a_x;
  logic [MAG_MU_W-1:0] mu_mag, mu_clip;
  logic [MAG_A_W-1:0]  a_mag;
  logic [MU_W-1:0]     mu_biased, work, shifted;
  logic [K_W-1:0]      k, sh;
  logic [SEG_W-1:0]    chord;
  logic [STEP_W-1:0]   step;
  logic [CODE_W-2:0]   body;
  logic                mu_sat;

  assign neg  = lin[LIN_W-1];
  assign mu_x = lin[LIN_W-1 -: MU_W];
  assign a_x  = lin[LIN_W-1 -: A_W];

  // sign/magnitude front end; both laws feed one working value
  always_comb begin
    mu_mag    = neg ? ~mu_x[MAG_MU_W-1:0] : mu_x[MAG_MU_W-1:0];
    a_mag     = neg ? ~a_x[MAG_A_W-1:0] : a_x[MAG_A_W-1:0];
    mu_clip   = (mu_mag > MAG_MU_W'(MU_CLIP)) ? MAG_MU_W'(MU_CLIP) : mu_mag;
    mu_biased = MU_W'(mu_clip) + MU_W'(MU_BIAS);
    work      = law ? MU_W'(a_mag) : mu_biased;
  end

  cmp_lead_finder #(.W(MU_W), .FLOOR(SEG_FLOOR), .OUT_W(K_W)) u_find (
    .val (work),
    .k   (k)
  );

  // shared step shifter and law-specific packing
  always_comb begin
    sh      = (law && k == '0) ? K_W'(1) : k;
    shifted = work >> sh;
    step    = shifted[STEP_W-1:0];
    mu_sat  = !law && (k > K_W'(MU_TOP_K));
    chord   = law ? k[SEG_W-1:0] : SEG_W'(k - K_W'(1));
    if (law)         body = {chord, step} ^ A_EVEN_MASK;
    else if (mu_sat) body = '0;
    else             body = ~{chord, step};
    code = {~neg, body};
  end
endmodule

// File: rtl/cmp_expand.sv
module cmp_expand
  import compander_pkg::*;
#(
  parameter int LIN_W = 16
) (
  input  logic [CODE_W-1:0] code,
  input  logic              law,
  output logic [LIN_W-1:0]  lin
);
  localparam int MAG_W  = MU_W - 1;
  localparam int BASE_W = STEP_W + 3;

  logic [CODE_W-2:0] f;
  logic [SEG_W-1:0]  seg, sh;
  logic [STEP_W-1:0] step;
  logic [BASE_W-1:0] base;
  logic [MAG_W-1:0]  wide, mag;
  logic [LIN_W-1:0]  mag_lin;

  always_comb begin
    f    = law ? (code[CODE_W-2:0] ^ A_EVEN_MASK) : ~code[CODE_W-2:0];
    seg  = f[CODE_W-2 -: SEG_W];
    step = f[STEP_W-1:0];
    // 2s+1, plus the implicit leading one except in A-law chord 0
    base = {2'b00, step, 1'b1} +
           ((law && seg == '0) ? BASE_W'(0) : BASE_W'(MU_BIAS - 1));
    sh   = law ? ((seg == '0) ? '0 : seg - 1'b1) : seg;
    wide = MAG_W'(base) << sh;
    mag  = law ? wide : wide - MAG_W'(MU_BIAS);
    mag_lin = law ? (LIN_W'(mag) << (LIN_W - A_W))
                  : (LIN_W'(mag) << (LIN_W - MU_W));
    lin  = code[CODE_W-1] ? mag_lin : -mag_lin;
  end
endmodule

// File: rtl/voice_compander.sv
module voice_compander
  import compander_pkg::*;
#(
  parameter int LIN_W = 16  // must be at least MU_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              law_sel,
  input  logic [LIN_W-1:0]  lin_in,
  output logic [CODE_W-1:0] code_out,
  input  logic [CODE_W-1:0] code_in,
  output logic [LIN_W-1:0]  lin_out
);
  logic [CODE_W-1:0] enc_code;
  logic [LIN_W-1:0]  dec_lin;
  logic              vld_q;

  cmp_encode #(.LIN_W(LIN_W)) u_enc (
    .lin  (lin_in),
    .law  (law_sel),
    .code (enc_code)
  );

  cmp_expand #(.LIN_W(LIN_W)) u_dec (
    .code (code_in),
    .law  (law_sel),
    .lin  (dec_lin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_out <= '0;
      lin_out  <= '0;
      vld_q    <= 1'b0;
    end else begin
      code_out <= enc_code;
      lin_out  <= dec_lin;
      vld_q    <= 1'b1;
    end
  end

  // R2
  sign_bit_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (code_out[CODE_W-1] == !$past(lin_in[LIN_W-1])));

  // R5
  mu_sat_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q && $past(!law_sel && !lin_in[LIN_W-1] &&
                   (lin_in[LIN_W-1 -: MU_W] >= MU_W'(MU_CLIP)))
    |-> (code_out == 8'h80));

  // R7
  a_zero_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q && $past(law_sel && lin_in[LIN_W-1 -: A_W] == '0)
    |-> (code_out == 8'hD5));

  // R8
  dec_pos_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q && $past(code_in[CODE_W-1]) |-> !lin_out[LIN_W-1]);

  // R8
  dec_neg_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q && $past(!code_in[CODE_W-1])
    |-> (lin_out[LIN_W-1] || lin_out == '0));

  // R9
  a_grid_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q && $past(law_sel) |-> (lin_out[2:0] == 3'b000));
endmodule

// File: tb/voice_compander_test.sv
`timescale 1ns/1ps
module voice_compander_test;
  localparam int NVEC = 21;

  logic        clk = 1'b0;
  logic        rst;
  logic        law_sel;
  logic [15:0] lin_in, lin_out;
  logic [7:0]  code_in, code_out;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #2 clk = ~clk;

  voice_compander #(.LIN_W(16)) uut (
    .clk      (clk),
    .rst      (rst),
    .law_sel  (law_sel),
    .lin_in   (lin_in),
    .code_out (code_out),
    .code_in  (code_in),
    .lin_out  (lin_out)
  );

  // {enc req, law, lin_in, expected code, dec req, code_in, expected lin_out}
  localparam logic [56:0] VEC [NVEC] = '{
    {4'd4, 1'b0, 16'h0000, 8'hFF, 4'd8, 8'hFF, 16'h0000}, // R4 R8
    {4'd4, 1'b0, 16'hFFFC, 8'h7F, 4'd8, 8'h7F, 16'h0000}, // R4 R8
    {4'd3, 1'b0, 16'h0078, 8'hF0, 4'd8, 8'h80, 16'h7D7C}, // R3 R8
    {4'd3, 1'b0, 16'h007C, 8'hEF, 4'd8, 8'h00, 16'h8284}, // R3 R8
    {4'd3, 1'b0, 16'h3F7C, 8'h8F, 4'd8, 8'hEF, 16'h0084}, // R3 R8
    {4'd4, 1'b0, 16'h7F78, 8'h80, 4'd8, 8'h5F, 16'hFE74}, // R4 R8
    {4'd5, 1'b0, 16'h7F7C, 8'h80, 4'd8, 8'hAF, 16'h0FFC}, // R5 R8
    {4'd5, 1'b0, 16'h7FFC, 8'h80, 4'd1, 8'hD5, 16'h02CC}, // R5 R1
    {4'd5, 1'b0, 16'h8000, 8'h00, 4'd8, 8'hFF, 16'h0000}, // R5 R8
    {4'd2, 1'b0, 16'hFE70, 8'h5F, 4'd8, 8'h80, 16'h7D7C}, // R2 R8
    {4'd3, 1'b0, 16'h0FA0, 8'hAF, 4'd8, 8'h00, 16'h8284}, // R3 R8
    {4'd1, 1'b0, 16'h00F8, 8'hE8, 4'd8, 8'hEF, 16'h0084}, // R1 R8
    {4'd7, 1'b1, 16'h0000, 8'hD5, 4'd9, 8'hD5, 16'h0008}, // R7 R9
    {4'd7, 1'b1, 16'hFFF8, 8'h55, 4'd9, 8'h55, 16'hFFF8}, // R7 R9
    {4'd7, 1'b1, 16'h7FF8, 8'hAA, 4'd9, 8'hAA, 16'h7E00}, // R7 R9
    {4'd7, 1'b1, 16'h8000, 8'h2A, 4'd9, 8'h2A, 16'h8200}, // R7 R9
    {4'd1, 1'b1, 16'h00F8, 8'hDA, 4'd9, 8'hC5, 16'h0108}, // R1 R9
    {4'd6, 1'b1, 16'h0100, 8'hC5, 4'd9, 8'hF5, 16'h0210}, // R6 R9
    {4'd6, 1'b1, 16'h0200, 8'hF5, 4'd9, 8'h7D, 16'hFCF0}, // R6 R9
    {4'd6, 1'b1, 16'h4000, 8'hA5, 4'd9, 8'hA5, 16'h4200}, // R6 R9
    {4'd2, 1'b1, 16'hFCE0, 8'h7D, 4'd9, 8'hD5, 16'h0008}  // R2 R9
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wrap_up;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 4);
    checks++;
    fails++;
    $display("FAIL R10 watchdog: got timeout expected completion");
    wrap_up();
  end

  initial begin
    rst = 1'b1; law_sel = 1'b0; lin_in = 16'h1234; code_in = 8'h80;
    repeat (3) @(negedge clk);
    chk("R10 reset code", {8'h00, code_out}, 16'h0000);
    chk("R10 reset lin", lin_out, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      law_sel = VEC[i][52];
      lin_in  = VEC[i][51:36];
      code_in = VEC[i][23:16];
      @(negedge clk);
      chk($sformatf("R%0d encode row %0d", VEC[i][56:53], i), {8'h00, code_out}, {8'h00, VEC[i][35:28]});
      chk($sformatf("R%0d expand row %0d", VEC[i][27:24], i), lin_out, VEC[i][15:0]);
    end

    // R10: no change before the edge, new values one clock later
    law_sel = 1'b0; lin_in = 16'h0078; code_in = 8'h80;
    #1;
    chk("R10 hold code", {8'h00, code_out}, 16'h007D);
    chk("R10 hold lin", lin_out, 16'h0008);
    @(negedge clk);
    chk("R10 latency code", {8'h00, code_out}, 16'h00F0);
    chk("R10 latency lin", lin_out, 16'h7D7C);

    // R10: changing only code_in leaves the encoder result alone
    code_in = 8'h7F;
    @(negedge clk);
    chk("R10 independent code", {8'h00, code_out}, 16'h00F0);
    chk("R8 negative zero", lin_out, 16'h0000);

    // R1: flipping the law with identical inputs
    law_sel = 1'b1;
    @(negedge clk);
    chk("R1 law flip code", {8'h00, code_out}, 16'h00D2);
    chk("R1 law flip lin", lin_out, 16'hFCB0);

    // R10: reset in mid-run clears both outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid reset code", {8'h00, code_out}, 16'h0000);
    chk("R10 mid reset lin", lin_out, 16'h0000);
    rst = 1'b0;

    wrap_up();
  end
endmodule